// File: doc/BRIEF.md
# Programmable Serial Baud Generator

This block derives the bit-timing enables of a serial port from the system clock, so that no extra clock domain is needed. Software sets an 8-bit rate value N and a 2-bit clock-select value n through a small write port. The system clock passes through a prescaler of 4^n, then through a reloading down counter of N+1, then through a divide-by-two stage. The result is a base tick that fires once every 2·4^n·(N+1) system clocks.

A mode input picks how the base tick is used. In asynchronous mode, the base tick is the 16x oversampling enable, and every sixteenth tick also raises a bit strobe. One bit therefore lasts 32·4^n·(N+1) clocks. In clock-synchronous mode, a serial clock flips on every base tick, and the bit strobe marks each low-to-high edge of that clock. One bit then lasts 4·4^n·(N+1) clocks. A phase machine tracks the mode and the serial clock level. Its states are:

- PH_IDLE: disabled or reloading; the serial clock is high.
- PH_ASYNC: oversampling.
- PH_SYNC_HI: serial clock high.
- PH_SYNC_LO: serial clock low.

The machine moves between states on these transitions:

- Any state goes to PH_IDLE when the enable is low or a write occurs.
- PH_IDLE and PH_ASYNC go to PH_ASYNC in asynchronous mode. In synchronous mode they go to PH_SYNC_LO on a base tick and to PH_SYNC_HI otherwise.
- PH_SYNC_HI goes to PH_SYNC_LO on a base tick.
- PH_SYNC_LO goes to PH_SYNC_HI on a base tick, and raises the strobe as it does.
- Either synchronous state goes to PH_ASYNC when the mode turns asynchronous.

Top module: `baud_gen_top`

## Requirements
- R1: After reset the rate value is 255 and the clock-select value is 0. In that state sample_tick and bit_strobe are 0 and sclk is 1, and with the enable high the first tick follows 512 clocks after the enable.
- R2: The clock-select value n (0..3) multiplies the base tick period by 4^n, giving prescale factors of 1, 4, 16 and 64.
- R3: In asynchronous mode (mode_sync=0), sample_tick is a one-cycle pulse. It rises first 2·4^n·(N+1) enabled clocks after the reload point, and then again at that same interval.
- R4: In asynchronous mode, bit_strobe is high together with every 16th sample_tick and at no other time, counting from the reload point.
- R5: In synchronous mode (mode_sync=1), sclk starts high and flips on every base tick, so its period is 4·4^n·(N+1) clocks. sample_tick stays 0 in this mode.
- R6: In synchronous mode, bit_strobe is high exactly in the cycle in which sclk goes from 0 to 1.
- R7: A write to the rate value (rate_we) or to the clock-select value (sel_we) reloads every counter and the phase, even with the enable low. No strobe is produced in the cycle after the write, and the new timing counts from the following cycle.
- R8: While en is 0, sample_tick and bit_strobe stay 0, sclk stays 1 and the counters are held at their reload values. Timing restarts from the reload point when en returns high.
- R9: A mode change while enabled keeps the count running. Going from synchronous to asynchronous mode returns sclk to 1 without a strobe, and sample_tick never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| mode_sync | input | 1 | 0: asynchronous oversampling, 1: clock-synchronous |
| rate_we | input | 1 | Write strobe for the rate value |
| rate_wdata | input | 8 | New rate value N |
| sel_we | input | 1 | Write strobe for the clock-select value |
| sel_wdata | input | 2 | New clock-select value n |
| sample_tick | output | 1 | Oversampling enable (asynchronous mode) |
| bit_strobe | output | 1 | One pulse per bit period |
| sclk | output | 1 | Serial clock level (synchronous mode), idles high |

## Verification
The assertions check the following on every cycle:
- Outputs go quiet after a low enable or after a write.
- sample_tick is never high in synchronous mode and is never high for two consecutive cycles.
- In asynchronous mode, a bit strobe always coincides with a tick.
- In synchronous mode, a bit strobe always coincides with a rising sclk.

Only the bench's scenarios can show the exact periods for each combination of N and n, and the 16-tick spacing of the strobe. The same holds for the reload point after writes and after re-enabling, and for the default rate after reset. These are compared every clock against a behavioural model of counts and periods.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ASYNC   = 2'd1,
        PH_SYNC_HI = 2'd2,
        PH_SYNC_LO = 2'd3
    } phase_t;

    // prescaler counter width for a power-of-four select of sel_w bits
    function automatic int pre_width(input int sel_w);
        return 2 * ((1 << sel_w) - 1);
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_tick
);
    localparam int PRE_W = baud_gen_pkg::pre_width(SEL_W);

    generate
        if (PRE_W == 0) begin : g_bypass
            assign pre_tick = run;
        end else begin : g_count
            logic [PRE_W-1:0] cnt;
            logic [PRE_W:0]   span;
            logic [PRE_W-1:0] lim;

            always_comb begin
                span = (PRE_W+1)'(1) << {sel, 1'b0};
                lim  = PRE_W'(span - 1'b1);
            end

            assign pre_tick = run && (cnt == lim);

            always_ff @(posedge clk) begin
                if (!rst_n || !run || pre_tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pre_tick,
    input  logic [RATE_W-1:0] reload_val,
    output logic              base_tick
);
    logic [RATE_W-1:0] cnt;
    logic              half;
    logic              div_tick;

    assign div_tick  = pre_tick && (cnt == '0);
    assign base_tick = div_tick && half;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= reload_val;
            half <= 1'b0;
        end else if (pre_tick) begin
            cnt  <= div_tick ? reload_val : cnt - 1'b1;
            half <= div_tick ? ~half : half;
        end
    end

    // R3: the divide-by-two stage never yields two adjacent base ticks
    a_r3_base_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick);
endmodule

// File: rtl/baud_phase_fsm.sv
module baud_phase_fsm #(
    parameter int OVS_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic reload,
    input  logic mode_sync,
    input  logic base_tick,
    output logic sample_tick,
    output logic bit_strobe,
    output logic sclk
);
    import baud_gen_pkg::*;

    phase_t           state, nxt;
    logic [OVS_W-1:0] sub;
    logic             run;

    assign run  = en && !reload;
    assign sclk = (state != PH_SYNC_LO);

    always_comb begin
        nxt = PH_IDLE;
        if (run) begin
            unique case (state)
                PH_IDLE, PH_ASYNC:
                    nxt = !mode_sync ? PH_ASYNC
                        : (base_tick ? PH_SYNC_LO : PH_SYNC_HI);
                PH_SYNC_HI:
                    nxt = !mode_sync ? PH_ASYNC
                        : (base_tick ? PH_SYNC_LO : PH_SYNC_HI);
                PH_SYNC_LO:
                    nxt = !mode_sync ? PH_ASYNC
                        : (base_tick ? PH_SYNC_HI : PH_SYNC_LO);
                default:
                    nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_tick <= 1'b0;
            bit_strobe  <= 1'b0;
            sub         <= '0;
        end else begin
            sample_tick <= run && !mode_sync && base_tick;
            bit_strobe  <= run && base_tick &&
                           (mode_sync ? (state == PH_SYNC_LO) : (&sub));
            if (run && !mode_sync) begin
                sub <= base_tick ? sub + 1'b1 : sub;
            end else begin
                sub <= '0;
            end
        end
    end

    // R8: disabled cycle produces nothing and parks sclk high
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!sample_tick && !bit_strobe && sclk));
    // R7: a write cycle produces no strobe
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reload) |-> (!sample_tick && !bit_strobe));
    // R4: asynchronous bit strobe always rides on a sample tick
    a_r4_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !$past(mode_sync)) |-> sample_tick);
    // R6: synchronous bit strobe only on a rising serial clock
    a_r6_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && $past(mode_sync)) |-> (sclk && !$past(sclk)));
    // R5: no oversampling tick in synchronous mode
    a_r5_no_tick_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_sync) |-> !sample_tick);
    // R9: ticks are single-cycle
    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick);
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
    parameter int          RATE_W   = 8,
    parameter int          SEL_W    = 2,
    parameter int          OVS_W    = 4,
    parameter logic [7:0]  RATE_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mode_sync,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              sel_we,
    input  logic [SEL_W-1:0]  sel_wdata,
    output logic              sample_tick,
    output logic              bit_strobe,
    output logic              sclk
);
    logic [RATE_W-1:0] rate_q, rate_nx;
    logic [SEL_W-1:0]  sel_q;
    logic              reload, run, pre_tick, base_tick;

    assign reload  = rate_we || sel_we;
    assign run     = en && !reload;
    assign rate_nx = rate_we ? rate_wdata : rate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_W'(RATE_RST);
            sel_q  <= '0;
        end else begin
            if (rate_we) rate_q <= rate_wdata;
            if (sel_we)  sel_q  <= sel_wdata;
        end
    end

    baud_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q), .pre_tick(pre_tick)
    );

    baud_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_tick(pre_tick),
        .reload_val(rate_nx), .base_tick(base_tick)
    );

    baud_phase_fsm #(.OVS_W(OVS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
        .mode_sync(mode_sync), .base_tick(base_tick),
        .sample_tick(sample_tick), .bit_strobe(bit_strobe), .sclk(sclk)
    );
endmodule

// File: tb/baud_gen_top_tb_top.sv
`timescale 1ns/1ps
module baud_gen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       mode_sync = 1'b0;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = 8'd0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'd0;
    logic       sample_tick, bit_strobe, sclk;

    always #2 clk = ~clk;  // 250 MHz

    baud_gen_top dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sync(mode_sync),
        .rate_we(rate_we), .rate_wdata(rate_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .sample_tick(sample_tick), .bit_strobe(bit_strobe), .sclk(sclk)
    );

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural model: counts of enabled clocks since the reload point
    int m_rate, m_sel, m_cnt, m_sub, m_period;
    bit m_sclk, e_tick, e_strb, m_base, prev_tick;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_rate = 255; m_sel = 0; m_cnt = 0; m_sub = 0;
            m_sclk = 1'b1; e_tick = 1'b0; e_strb = 1'b0;
        end else if (!en || rate_we || sel_we) begin
            if (rate_we) m_rate = rate_wdata;
            if (sel_we)  m_sel  = sel_wdata;
            m_cnt = 0; m_sub = 0; m_sclk = 1'b1;
            e_tick = 1'b0; e_strb = 1'b0;
        end else begin
            m_period = 2 * (1 << (2 * m_sel)) * (m_rate + 1);
            m_base = (m_cnt == m_period - 1);
            m_cnt  = m_base ? 0 : m_cnt + 1;
            if (!mode_sync) begin
                e_tick = m_base;
                e_strb = m_base && (m_sub == 15);
                if (m_base) m_sub = (m_sub + 1) % 16;
                m_sclk = 1'b1;
            end else begin
                e_tick = 1'b0;
                e_strb = m_base && !m_sclk;
                if (m_base) m_sclk = !m_sclk;
                m_sub = 0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(cur_req, "sample_tick", sample_tick, e_tick);
            check(cur_req, "bit_strobe", bit_strobe, e_strb);
            check(cur_req, "sclk", sclk, m_sclk);
            if (prev_tick && sample_tick)
                check("R9", "back-to-back tick", 1, 0);
            prev_tick = sample_tick;
        end
    end

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input bit do_rate, input int r, input bit do_sel, input int s);
        @(negedge clk);
        rate_we = do_rate; rate_wdata = 8'(r);
        sel_we  = do_sel;  sel_wdata  = 2'(s);
        @(negedge clk);
        rate_we = 1'b0; sel_we = 1'b0;
    endtask

    // count ticks seen over a window, returned for directed checks
    task automatic count_ticks(input int n, output int ticks, output int strobes);
        ticks = 0; strobes = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ticks += sample_tick;
            strobes += bit_strobe;
        end
    endtask

    initial begin : watchdog
        wait (cycles > 190000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int tk, sb;
        run_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset sample_tick", sample_tick, 0);
        check("R1", "reset bit_strobe", bit_strobe, 0);
        check("R1", "reset sclk", sclk, 1);
        cmp_on = 1'b1;

        // R1: default rate 255, sel 0 -> 512-clock tick period
        cur_req = "R1";
        en = 1'b1;
        count_ticks(1030, tk, sb);
        check("R1", "default ticks in 1030 clocks", tk, 2);

        // R3: N=3, n=0 -> period 8, bit 128
        en = 1'b0;
        write_cfg(1, 3, 1, 0);
        cur_req = "R3";
        en = 1'b1;
        count_ticks(400, tk, sb);
        check("R3", "ticks N=3", tk, 50);

        // R4: N=0, n=0 -> period 2, strobe every 32 clocks
        write_cfg(1, 0, 0, 0);
        cur_req = "R4";
        count_ticks(320, tk, sb);
        check("R4", "ticks N=0", tk, 160);
        check("R4", "strobes N=0", sb, 10);

        // R2: each prescale factor
        cur_req = "R2";
        write_cfg(1, 0, 1, 1);   // period 8
        count_ticks(80, tk, sb);
        check("R2", "ticks n=1", tk, 10);
        write_cfg(1, 2, 1, 2);   // period 96
        count_ticks(960, tk, sb);
        check("R2", "ticks n=2", tk, 10);
        write_cfg(1, 1, 1, 3);   // period 256
        count_ticks(4096, tk, sb);
        check("R2", "ticks n=3", tk, 16);
        check("R2", "strobes n=3", sb, 1);

        // R5: synchronous mode N=2, n=0 -> sclk half period 6
        en = 1'b0;
        mode_sync = 1'b1;
        write_cfg(1, 2, 1, 0);
        cur_req = "R5";
        en = 1'b1;
        count_ticks(240, tk, sb);
        check("R5", "no ticks in sync", tk, 0);

        // R6: strobes on rising sclk, n=1 N=0 -> bit 16 clocks
        write_cfg(1, 0, 1, 1);
        cur_req = "R6";
        count_ticks(160, tk, sb);
        check("R6", "sync strobes", sb, 10);

        // R7: writes while running and while disabled
        cur_req = "R7";
        for (int k = 0; k < 12; k++) begin
            write_cfg(1, k % 5, (k % 3) == 0, k % 2);
            run_cycles(7 + 5 * k);
        end
        mode_sync = 1'b0;
        en = 1'b0;
        write_cfg(1, 1, 1, 0);
        en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            write_cfg(k[0], 2 + k, !k[0], k % 2);
            run_cycles(40 + 9 * k);
        end

        // R8: enable toggling in both modes
        cur_req = "R8";
        write_cfg(1, 0, 1, 0);
        for (int k = 0; k < 20; k++) begin
            mode_sync = k[2];
            en = 1'b0;
            run_cycles(1 + (k % 4));
            en = 1'b1;
            run_cycles(3 + 11 * (k % 5));
        end

        // R9: mode flips while enabled
        cur_req = "R9";
        write_cfg(1, 1, 1, 0);
        for (int k = 0; k < 16; k++) begin
            mode_sync = ~mode_sync;
            run_cycles(5 + 7 * k);
        end
        run_cycles(10);

        cmp_on = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule